// File: doc/BRIEF.md
# Staged Leading-One Finder

This block locates the earliest set bit in a 16-bit window of an entropy-coded bitstream. Bit 0 of the window is the first bit of the stream. The result is the index of that bit, from 0 to 15, together with a found flag. In prefix codes the first set bit usually falls in the first few positions, so the window is split into three unequal segments. The first segment covers two bits, the second covers four and the third covers ten. Each segment has its own detector with its own operand register.

The segments are examined one after another, in priority order. The first segment's detector is loaded on every accepted start. The second segment's detector is loaded only when the first segment holds no '1'. The third segment's detector is loaded only when both earlier segments are empty. When a segment is not loaded, its operand register keeps its old value, so its logic does not switch. A single final encoder turns the result of the segment that hit into the 4-bit index.

The parent decoder raises the enable only while the current codeword needs this search. It pulses the start strobe together with the window and then waits for the done strobe. An early hit costs one cycle and a late hit costs three.

Top module: `ldet_staged_top`

## Requirements
- R1: On done with found=1, pos equals the index of the lowest-numbered set bit of the window captured at start, where bit 0 is the earliest stream bit.
- R2: Done rises exactly 1 cycle after an accepted start when the first set bit is at index 0–1, 2 cycles when it is at 2–5, and 3 cycles when it is at 6–15. A later segment's operand register changes only in the cycle its stage is entered.
- R3: An all-zero window gives done 3 cycles after start, with found=0 and pos=0.
- R4: While en is low, start is ignored. Dropping en during a search abandons it, and no done follows.
- R5: A start raised while a search is in progress and done is low is ignored. The search in progress completes with its own result, and no extra done follows.
- R6: A start raised in the same cycle as done is accepted. Its result follows with its own latency, without any idle cycle in between.
- R7: Done is a single-cycle strobe. While done is low, pos and found read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Search enable; low keeps the block idle and quiet |
| start | input | 1 | Start strobe; captures win |
| win | input | 16 | Bit window; bit 0 is the earliest stream bit |
| pos | output | 4 | Index of the first set bit, valid with done |
| found | output | 1 | A set bit was present, valid with done |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default split: a 16-bit window divided into segments of 2, 4 and 10 bits. With this split every segment boundary can be reached by the stimulus: indices 1/2 and 5/6, the last index 15, and the empty window. The random windows choose the first-set index uniformly over all seventeen outcomes and fill the bits above it at random. Because of this, the rare late-stage cases occur as often as the common early ones. Back-to-back starts, starts while busy and dropping the enable in the middle of a search are driven as directed cases.

// File: rtl/ldet_pkg.sv
package ldet_pkg;

    // Width of a segment-local result index; covers windows up to 32 bits.
    localparam int LDET_IDX_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_A    = 2'd1,
        ST_B    = 2'd2,
        ST_C    = 2'd3
    } stage_e;

    // Result of one segment detector, index already offset into the window.
    typedef struct packed {
        logic                  hit;
        logic [LDET_IDX_W-1:0] idx;
    } det_res_t;

endpackage

// File: rtl/ldet_subdet.sv
module ldet_subdet
    import ldet_pkg::*;
#(
    parameter int W   = 2,
    parameter int OFS = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] din,
    output logic [W-1:0] opd,
    output det_res_t     res
);

    // Operand register: loads only when this stage is entered, else holds.
    always_ff @(posedge clk) begin
        if (rst) begin
            opd <= '0;
        end else if (ld) begin
            opd <= din;
        end
    end

    // Lowest set bit wins; scan from the top so the lowest assignment stays.
    always_comb begin
        res = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (opd[i]) begin
                res.hit = 1'b1;
                res.idx = LDET_IDX_W'(OFS + i);
            end
        end
    end

endmodule

// File: rtl/ldet_seq.sv
module ldet_seq
    import ldet_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   start,
    input  logic   hit_a,
    input  logic   hit_b,
    output stage_e state_q,
    output logic   accept,
    output logic   ld_b,
    output logic   ld_c,
    output logic   done
);

    stage_e state_d;

    always_comb begin
        done = ((state_q == ST_A) && hit_a) ||
               ((state_q == ST_B) && hit_b) ||
               (state_q == ST_C);
        accept = en && start && ((state_q == ST_IDLE) || done);
        ld_b   = en && (state_q == ST_A) && !hit_a;
        ld_c   = en && (state_q == ST_B) && !hit_b;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else if (accept) begin
            state_d = ST_A;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_A:    state_d = hit_a ? ST_IDLE : ST_B;
                ST_B:    state_d = hit_b ? ST_IDLE : ST_C;
                ST_C:    state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/ldet_penc.sv
module ldet_penc
    import ldet_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  stage_e           state_q,
    input  det_res_t         res_a,
    input  det_res_t         res_b,
    input  det_res_t         res_c,
    output logic [POS_W-1:0] pos,
    output logic             found
);

    det_res_t sel;

    // Only the segment of the current stage is consulted.
    always_comb begin
        unique case (state_q)
            ST_A:    sel = res_a;
            ST_B:    sel = res_b;
            ST_C:    sel = res_c;
            default: sel = '0;
        endcase
        found = sel.hit;
        pos   = sel.hit ? POS_W'(sel.idx) : '0;
    end

endmodule

// File: rtl/ldet_staged_top.sv
module ldet_staged_top
    import ldet_pkg::*;
#(
    parameter int WIN_W = 16,
    parameter int A_W   = 2,
    parameter int B_W   = 4,
    localparam int C_W   = WIN_W - A_W - B_W,
    localparam int POS_W = $clog2(WIN_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic [WIN_W-1:0] win,
    output logic [POS_W-1:0] pos,
    output logic             found,
    output logic             done
);

    stage_e           state_q;
    logic             accept;
    logic             ld_b;
    logic             ld_c;
    logic             hit_a;
    logic             hit_b;
    logic             pe_found;
    logic [POS_W-1:0] pe_pos;
    logic [WIN_W-1:A_W] tail_q;
    logic [A_W-1:0]   opd_a;
    logic [B_W-1:0]   opd_b;
    logic [C_W-1:0]   opd_c;
    det_res_t         res_a;
    det_res_t         res_b;
    det_res_t         res_c;

    // Later-segment bits wait here until their stage is entered.
    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
        end else if (accept) begin
            tail_q <= win[WIN_W-1:A_W];
        end
    end

    ldet_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .start   (start),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .state_q (state_q),
        .accept  (accept),
        .ld_b    (ld_b),
        .ld_c    (ld_c),
        .done    (done)
    );

    ldet_subdet #(.W(A_W), .OFS(0)) u_det_a (
        .clk (clk),
        .rst (rst),
        .ld  (accept),
        .din (win[A_W-1:0]),
        .opd (opd_a),
        .res (res_a)
    );

    ldet_subdet #(.W(B_W), .OFS(A_W)) u_det_b (
        .clk (clk),
        .rst (rst),
        .ld  (ld_b),
        .din (tail_q[A_W+B_W-1:A_W]),
        .opd (opd_b),
        .res (res_b)
    );

    ldet_subdet #(.W(C_W), .OFS(A_W + B_W)) u_det_c (
        .clk (clk),
        .rst (rst),
        .ld  (ld_c),
        .din (tail_q[WIN_W-1:A_W+B_W]),
        .opd (opd_c),
        .res (res_c)
    );

    assign hit_a = res_a.hit;
    assign hit_b = res_b.hit;

    ldet_penc #(.POS_W(POS_W)) u_penc (
        .state_q (state_q),
        .res_a   (res_a),
        .res_b   (res_b),
        .res_c   (res_c),
        .pos     (pe_pos),
        .found   (pe_found)
    );

    // Results are shown only on the done cycle.
    assign pos   = done ? pe_pos : '0;
    assign found = done & pe_found;

endmodule

// File: rtl/ldet_chk.sv
module ldet_chk
    import ldet_pkg::*;
#(
    parameter int POS_W = 4,
    parameter int B_W   = 4,
    parameter int C_W   = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             done,
    input logic             found,
    input logic [POS_W-1:0] pos,
    input stage_e           state_q,
    input logic             accept,
    input logic             ld_b,
    input logic             ld_c,
    input logic [B_W-1:0]   opd_b,
    input logic [C_W-1:0]   opd_c
);

    // R3
    empty_pos_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !found) |-> (pos == '0));

    // R4
    en_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state_q == ST_IDLE));

    // R4
    en_low_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !done);

    // R6
    accept_enters_a_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state_q == ST_A));

    // R2
    b_operand_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_b |=> $stable(opd_b));

    // R2
    c_operand_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_c |=> $stable(opd_c));

    // R7
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !accept) |=> !done);

    // R7
    found_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> done);

endmodule

bind ldet_staged_top ldet_chk #(.POS_W(POS_W), .B_W(B_W), .C_W(C_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .done    (done),
    .found   (found),
    .pos     (pos),
    .state_q (state_q),
    .accept  (accept),
    .ld_b    (ld_b),
    .ld_c    (ld_c),
    .opd_b   (opd_b),
    .opd_c   (opd_c)
);

// File: tb/tb_ldet_staged_top.sv
module tb_ldet_staged_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN_W = 16;
    localparam int POS_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             start = 1'b0;
    logic [WIN_W-1:0] win = '0;
    logic [POS_W-1:0] pos;
    logic             found;
    logic             done;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ldet_staged_top dut (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .start (start),
        .win   (win),
        .pos   (pos),
        .found (found),
        .done  (done)
    );

    function automatic int first_one(logic [WIN_W-1:0] w);
        for (int i = 0; i < WIN_W; i++) begin
            if (w[i]) return i;
        end
        return -1;
    endfunction

    function automatic int want_lat(int p);
        if (p < 0) return 3;
        if (p < 2) return 1;
        if (p < 6) return 2;
        return 3;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiet_cycles(int n, string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(!done, req, "done while idle", done, 0);
            check(pos == 0 && !found, "R7", "outputs while not done", pos, 0);
        end
    endtask

    // Called at a negedge; drives the start there and returns at the done negedge.
    task automatic run(logic [WIN_W-1:0] w);
        int p;
        int lat;
        int got;
        p   = first_one(w);
        lat = want_lat(p);
        got = 0;
        en    = 1'b1;
        start = 1'b1;
        win   = w;
        @(negedge clk);
        start = 1'b0;
        win   = WIN_W'($urandom);
        for (int k = 1; k <= 4; k++) begin
            if (done) begin
                got = k;
                break;
            end
            check(pos == 0 && !found, "R7", "outputs before done", pos, 0);
            if (k < 4) @(negedge clk);
        end
        check(got == lat, "R2", "latency", got, lat);
        if (p < 0) begin
            check(!found, "R3", "found on empty window", found, 0);
            check(pos == 0, "R3", "pos on empty window", pos, 0);
        end else begin
            check(found, "R1", "found", found, 1);
            check(int'(pos) == p, "R1", "pos", pos, p);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [WIN_W-1:0] w;
        int p;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !found && pos == 0, "R7", "reset outputs", {done, found}, 0);

        // Directed boundaries of each segment.
        run(16'h0001);
        run(16'h0002);
        run(16'h0004);
        run(16'h0020);
        run(16'h0040);
        run(16'h8000);
        run(16'h0000);
        run(16'hFFF8);
        // R6: the calls above chain a start onto each done cycle.
        quiet_cycles(2, "R6");

        // R5: start while busy is ignored.
        en = 1'b1; start = 1'b1; win = 16'h0200;
        @(negedge clk);
        win = 16'h0001;
        check(!done, "R5", "done early", done, 0);
        @(negedge clk);
        start = 1'b0;
        check(!done, "R5", "done early", done, 0);
        @(negedge clk);
        check(done && found && pos == 9, "R5", "busy result pos", pos, 9);
        quiet_cycles(3, "R5");

        // R4: start with en low is ignored.
        en = 1'b0; start = 1'b1; win = 16'h0001;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R4", "done with en low", done, 0);
        quiet_cycles(3, "R4");

        // R4: dropping en mid-search abandons it.
        en = 1'b1; start = 1'b1; win = 16'h0400;
        @(negedge clk);
        start = 1'b0; en = 1'b0;
        quiet_cycles(4, "R4");
        en = 1'b1;
        @(negedge clk);

        // Random windows, first-set index uniform over all outcomes.
        for (int n = 0; n < 400; n++) begin
            p = $urandom_range(0, WIN_W);
            if (p == WIN_W) w = '0;
            else w = (WIN_W'($urandom) << (p + 1)) | (WIN_W'(1) << p);
            if ($urandom_range(0, 3) == 0) quiet_cycles(1 + $urandom_range(0, 2), "R6");
            run(w);
        end
        quiet_cycles(2, "R7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule